// File: doc/BRIEF.md
# Receive Idle Time-Out Counter

This block is a 16-bit down-counter that two receive channels share. It normally behaves as a plain programmable timer. A host starts it with a start command and halts it with a stop command. It counts down once per count-clock enable pulse from a preload value built from an upper byte and a lower byte. When it reaches zero it raises a ready flag.

Each channel can also switch the counter into a receive time-out mode with its own command code. In this mode the start and stop commands have no effect. The count is reloaded every time an enabled channel moves a received character into its receive FIFO. The ready flag therefore goes up only once the line has been quiet for the whole programmed interval.

A typical setup programs the preload to just over one character time. The host is then interrupted as soon as a burst of data ends, even if the burst was too short to fill the FIFO. Because the last character starts the count whether or not the FIFO has since been read empty, a line that stays marking for too long is reported too. When both channels enable the mode, a character on either channel restarts the count, so the time-out fires only when both are idle.

Top module: `rx_idle_timeout`

## Requirements
- R1: After a synchronous active-low reset, `count` is 0, `ctr_ready` is 0, `irq` is 0, and time-out mode is off on every channel.
- R2: A command write of code 4'hA on a channel turns time-out mode on for that channel. Code 4'hC turns it off. Other codes leave that channel's mode unchanged. The counter is in time-out mode while at least one channel has it on.
- R3: In time-out mode, a `rx_char_xfer` pulse on a channel whose mode is on loads `count` with {`preload_hi`,`preload_lo`} at the next clock edge, starts counting and clears `ctr_ready`. This happens whether or not the host has read the FIFO since.
- R4: While running, `count` drops by one on each edge where `cnt_tick` is 1, and it holds its value on edges where `cnt_tick` is 0.
- R5: A tick taken at a count of 1 (or of 0 just after a zero load) leaves `count` at 0, sets `ctr_ready` and stops counting. The counter never wraps below zero.
- R6: Entering time-out mode, or leaving it, stops the counter. After entering, no counting takes place until the first character transfer on an enabled channel.
- R7: A character transfer on any enabled channel restarts the interval. Transfers on a channel whose mode is off have no effect on `count` or `ctr_ready`.
- R8: Outside time-out mode, code 4'h8 loads the preload and starts counting with `ctr_ready` cleared, and code 4'h9 stops counting and clears `ctr_ready`. A stop wins over a start written on the same edge. In time-out mode both codes are ignored.
- R9: A `stop_rd` pulse clears `ctr_ready` at the next edge, unless the counter expires on that same edge. In time-out mode, `stop_rd` does not stop the count.
- R10: `irq` is 1 exactly when `ctr_ready` is 1 and `irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| preload_hi | input | 8 | Upper byte of the reload value |
| preload_lo | input | 8 | Lower byte of the reload value |
| cnt_tick | input | 1 | Count-clock enable, one pulse per decrement |
| cmd_wr | input | 2 | Per-channel command write strobe |
| cmd_code | input | 8 | Per-channel 4-bit command codes, channel n in bits [4n+3:4n] |
| rx_char_xfer | input | 2 | Per-channel strobe: a character entered the receive FIFO |
| stop_rd | input | 1 | Stop-counter register read, clears the ready flag |
| irq_en | input | 1 | Interrupt enable |
| count | output | 16 | Current counter value |
| ctr_ready | output | 1 | Counter-ready flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench applies each input from the falling edge. Every command, transfer, tick or read is registered at the following rising edge, so `count` and `ctr_ready` show its effect one cycle after it is applied. `irq` follows `ctr_ready` and `irq_en` with no further delay. The bench keeps a behavioural model that it updates at each rising edge from the same inputs. It compares all three outputs 1 ns after that edge, so every check lands in the cycle where the result is due. This also exposes any result that arrives a cycle early or late.

// File: rtl/rxto_pkg.sv
// Shared command codes and the request bundle passed from the mode
// control to the down-counter. Assumes 4-bit per-channel command codes.
package rxto_pkg;
    localparam logic [3:0] CMD_START   = 4'h8;
    localparam logic [3:0] CMD_STOP    = 4'h9;
    localparam logic [3:0] CMD_TMO_ON  = 4'hA;
    localparam logic [3:0] CMD_TMO_OFF = 4'hC;
    localparam int         CMD_W       = 4;

    // One cycle of requests toward the counter.
    typedef struct packed {
        logic load;      // reload from preload and run
        logic halt;      // stop running (highest priority)
        logic clr_ready; // clear ready together with halt
    } ctr_req_t;
endpackage

// File: rtl/rxto_mode_ctl.sv
// Per-channel time-out mode flags and command decode. Turns command
// writes and character-transfer strobes into load/halt requests.
// Assumes at most one command per channel per cycle; the mode seen by
// start/stop/restart decode is the registered one.
module rxto_mode_ctl
    import rxto_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       cmd_wr,
    input  logic [NCH*CMD_W-1:0] cmd_code,
    input  logic [NCH-1:0]       char_xfer,
    output logic                 mode_on,
    output ctr_req_t             req
);
    logic [NCH-1:0] en_q;
    logic [NCH-1:0] en_d;
    logic [NCH-1:0] start_hit;
    logic [NCH-1:0] stop_hit;
    logic           mode_next;
    logic           restart;

    // Per-channel decode of the command code.
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [CMD_W-1:0] code;
        assign code         = cmd_code[g*CMD_W +: CMD_W];
        assign en_d[g]      = (cmd_wr[g] && code == CMD_TMO_ON)  ? 1'b1 :
                              (cmd_wr[g] && code == CMD_TMO_OFF) ? 1'b0 : en_q[g];
        assign start_hit[g] = cmd_wr[g] && code == CMD_START;
        assign stop_hit[g]  = cmd_wr[g] && code == CMD_STOP;

        // R2: the enable code sets this channel's mode flag at the next edge
        a_r2_enable_ch: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_wr[g] && code == CMD_TMO_ON) |=> en_q[g]);
        // R2: the disable code clears this channel's mode flag
        a_r2_disable_ch: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_wr[g] && code == CMD_TMO_OFF) |=> !en_q[g]);
    end

    // Registers the per-channel mode flags.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    // Forms the counter requests from mode, commands and transfers.
    always_comb begin
        mode_on       = |en_q;
        mode_next     = |en_d;
        restart       = |(char_xfer & en_q);
        req.halt      = (mode_on != mode_next) || (!mode_on && |stop_hit);
        req.clr_ready = !mode_on && |stop_hit;
        req.load      = mode_on ? restart : |start_hit;
    end
endmodule

// File: rtl/rxto_down_counter.sv
// Loadable down-counter that saturates at zero and flags expiry.
// Assumes tick is a single-cycle enable; halt outranks load, and load
// outranks counting.
module rxto_down_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] preload,
    input  logic          load,
    input  logic          halt,
    input  logic          clr_ready,
    input  logic          rd_clr,
    output logic [CW-1:0] count,
    output logic          running,
    output logic          ready
);
    logic          expire;
    logic          ready_d;
    logic [CW-1:0] count_d;
    logic          running_d;

    // Next-state for count, run flag and ready flag.
    always_comb begin
        count_d   = count;
        running_d = running;
        expire    = 1'b0;
        if (halt) begin
            running_d = 1'b0;
        end else if (load) begin
            count_d   = preload;
            running_d = 1'b1;
        end else if (running && tick) begin
            if (count <= CW'(1)) begin
                count_d   = '0;
                running_d = 1'b0;
                expire    = 1'b1;
            end else begin
                count_d = count - CW'(1);
            end
        end
        if (expire)                                     ready_d = 1'b1;
        else if ((load && !halt) || (halt && clr_ready) || rd_clr) ready_d = 1'b0;
        else                                            ready_d = ready;
    end

    // Registers the counter state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            running <= 1'b0;
            ready   <= 1'b0;
        end else begin
            count   <= count_d;
            running <= running_d;
            ready   <= ready_d;
        end
    end

    // R5: the count never wraps from zero upward without a load
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !load) |=> count == '0);
    // R5: ready is only ever seen with the count at zero
    a_r5_ready_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> count == '0);
    // R4: one tick while running moves the count down by exactly one
    a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && count > CW'(1) && !load && !halt) |=> count == $past(count) - CW'(1));
    // R3: a load takes the preload and clears ready
    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !halt) |=> (count == $past(preload) && !ready && running));
endmodule

// File: rtl/rx_idle_timeout.sv
// Shared counter/timer with a receive idle time-out mode. Joins the
// mode control and the down-counter and forms the interrupt request.
// Assumes all inputs are synchronous to clk.
module rx_idle_timeout #(
    parameter int NCH   = 2,
    parameter int PRE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PRE_W-1:0]     preload_hi,
    input  logic [PRE_W-1:0]     preload_lo,
    input  logic                 cnt_tick,
    input  logic [NCH-1:0]       cmd_wr,
    input  logic [NCH*4-1:0]     cmd_code,
    input  logic [NCH-1:0]       rx_char_xfer,
    input  logic                 stop_rd,
    input  logic                 irq_en,
    output logic [2*PRE_W-1:0]   count,
    output logic                 ctr_ready,
    output logic                 irq
);
    import rxto_pkg::*;
    localparam int CW = 2 * PRE_W;

    ctr_req_t      req;
    logic          mode_on;
    logic          running;
    logic [CW-1:0] preload;

    assign preload = {preload_hi, preload_lo};

    rxto_mode_ctl #(.NCH(NCH)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_code  (cmd_code),
        .char_xfer (rx_char_xfer),
        .mode_on   (mode_on),
        .req       (req)
    );

    rxto_down_counter #(.CW(CW)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (cnt_tick),
        .preload   (preload),
        .load      (req.load),
        .halt      (req.halt),
        .clr_ready (req.clr_ready),
        .rd_clr    (stop_rd),
        .count     (count),
        .running   (running),
        .ready     (ctr_ready)
    );

    // Interrupt request follows the ready flag under its enable.
    always_comb irq = ctr_ready && irq_en;

    // R8: in time-out mode with no transfer and no tick, commands leave the count alone
    a_r8_cmds_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_on && !(|rx_char_xfer) && !cnt_tick) |=> $stable(count));
    // R6: entering time-out mode leaves the counter stopped
    a_r6_idle_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_on) |-> !running);
    // R9: a read clears ready unless the count expires on the same edge
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_rd && !(running && cnt_tick)) |=> !ctr_ready);
endmodule

// File: tb/rx_idle_timeout_bench.sv
`timescale 1ns/100ps
// Bench: behavioural model updated at each rising edge, outputs compared
// 1 ns later; stimulus changes only on falling edges.
module rx_idle_timeout_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] preload_hi = '0, preload_lo = '0;
    logic       cnt_tick = 1'b0;
    logic [1:0] cmd_wr = '0;
    logic [7:0] cmd_code = '0;
    logic [1:0] rx_char_xfer = '0;
    logic       stop_rd = 1'b0;
    logic       irq_en = 1'b0;
    logic [15:0] count;
    logic       ctr_ready, irq;

    int    vectors = 0, fails = 0;
    string cur_req = "R1";

    // model state
    bit m_en[2];
    int m_cnt;
    bit m_run, m_rdy;

    always #2.5 clk = ~clk;

    rx_idle_timeout u_rx_idle_timeout (
        .clk(clk), .rst_n(rst_n), .preload_hi(preload_hi), .preload_lo(preload_lo),
        .cnt_tick(cnt_tick), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
        .rx_char_xfer(rx_char_xfer), .stop_rd(stop_rd), .irq_en(irq_en),
        .count(count), .ctr_ready(ctr_ready), .irq(irq));

    task automatic model_edge();
        bit mq, mn, restart, start, stop, halt, load, expire;
        bit nen[2];
        if (!rst_n) begin
            m_en[0] = 0; m_en[1] = 0; m_cnt = 0; m_run = 0; m_rdy = 0;
            return;
        end
        mq = m_en[0] | m_en[1];
        restart = 0; start = 0; stop = 0; expire = 0;
        nen = m_en;
        for (int ch = 0; ch < 2; ch++) begin
            logic [3:0] c;
            c = cmd_code[ch*4 +: 4];
            if (rx_char_xfer[ch] && m_en[ch]) restart = 1;
            if (cmd_wr[ch]) begin
                if (c == 4'hA) nen[ch] = 1;
                else if (c == 4'hC) nen[ch] = 0;
                else if (c == 4'h8) start = 1;
                else if (c == 4'h9) stop = 1;
            end
        end
        mn = nen[0] | nen[1];
        halt = (mq != mn) || (!mq && stop);
        load = mq ? restart : start;
        if (halt) begin
            m_run = 0;
            if (!mq && stop) m_rdy = 0;
        end else if (load) begin
            m_cnt = {preload_hi, preload_lo}; m_run = 1; m_rdy = 0;
        end else if (m_run && cnt_tick) begin
            if (m_cnt <= 1) begin m_cnt = 0; m_run = 0; m_rdy = 1; expire = 1; end
            else m_cnt = m_cnt - 1;
        end
        if (!expire && stop_rd) m_rdy = 0;
        m_en = nen;
    endtask

    task automatic check(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // One clock: model at the edge, compare 1 ns after, return at falling edge.
    task automatic cyc();
        @(posedge clk);
        model_edge();
        #1;
        check(cur_req, "count", int'(count), m_cnt);
        check(cur_req, "ready", int'(ctr_ready), int'(m_rdy));
        check("R10", "irq", int'(irq), int'(m_rdy & irq_en));
        @(negedge clk);
    endtask

    task automatic cmd(int ch, logic [3:0] code);
        cmd_wr[ch] = 1'b1; cmd_code[ch*4 +: 4] = code;
        cyc();
        cmd_wr = '0; cmd_code = '0;
    endtask

    task automatic xfer(logic [1:0] m);
        rx_char_xfer = m; cyc(); rx_char_xfer = '0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin cnt_tick = 1'b1; cyc(); end
        cnt_tick = 1'b0;
    endtask

    task automatic rd();
        stop_rd = 1'b1; cyc(); stop_rd = 1'b0;
    endtask

    initial begin : watchdog
        #(5 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        check("R1", "reset count", int'(count), 0);
        check("R1", "reset ready", int'(ctr_ready), 0);

        // R8: normal start, R4 counting, R5 expiry and saturation, R10 irq
        cur_req = "R8";
        preload_hi = 8'h00; preload_lo = 8'h05; irq_en = 1'b1;
        cmd(0, 4'h8);
        check("R8", "start loads", int'(count), 5);
        cur_req = "R4";
        cyc(); cyc();
        cnt_tick = 1'b1; cyc(); cnt_tick = 1'b0; cyc(); // one tick, then hold
        check("R4", "one step", int'(count), 4);
        cur_req = "R5";
        ticks(6);
        check("R5", "saturates at zero", int'(count), 0);
        check("R5", "ready set", int'(ctr_ready), 1);
        check("R10", "irq raised", int'(irq), 1);
        irq_en = 1'b0; cyc();
        check("R10", "irq masked", int'(irq), 0);
        irq_en = 1'b1;
        // R9: read clears ready
        cur_req = "R9";
        rd();
        check("R9", "read clears", int'(ctr_ready), 0);

        // R8: stop mid-count halts; stop wins over start on same edge
        cur_req = "R8";
        cmd(1, 4'h8); ticks(2);
        cmd(1, 4'h9); ticks(3);
        check("R8", "stop halts", int'(count), 3);
        cmd_wr = 2'b11; cmd_code = {4'h9, 4'h8}; cyc(); cmd_wr = '0; cmd_code = '0;
        ticks(2);

        // R2/R6: enable ch0, no counting before first character
        cur_req = "R6";
        cmd(0, 4'hA); ticks(4);
        check("R6", "idle after enable", int'(count), 3);
        // R7: transfer on disabled channel ignored
        cur_req = "R7";
        xfer(2'b10); ticks(2);
        check("R7", "ch1 ignored", int'(count), 3);
        // R3: transfer on ch0 reloads
        cur_req = "R3";
        preload_hi = 8'h00; preload_lo = 8'h04;
        xfer(2'b01);
        check("R3", "reload", int'(count), 4);
        // R8: start/stop ignored in time-out mode
        cur_req = "R8";
        cmd(1, 4'h9); cmd(0, 4'h8); ticks(1);
        check("R8", "cmds ignored", int'(count), 3);
        // R9: read does not stop the count in time-out mode
        cur_req = "R9";
        rd(); ticks(1);
        check("R9", "read keeps running", int'(count), 2);
        // R5: expiry; read on the expiring edge leaves ready set
        cur_req = "R5";
        ticks(1);
        stop_rd = 1'b1; cnt_tick = 1'b1; cyc(); stop_rd = 1'b0; cnt_tick = 1'b0;
        check("R9", "expire beats read", int'(ctr_ready), 1);
        // R3: later character (FIFO long since read) restarts and clears ready
        cur_req = "R3";
        xfer(2'b01);
        check("R3", "ready cleared by restart", int'(ctr_ready), 0);

        // R7: both channels enabled, either restarts
        cur_req = "R7";
        cmd(1, 4'hA);
        xfer(2'b01);
        for (int i = 0; i < 4; i++) begin
            ticks(3);
            xfer((i % 2) ? 2'b01 : 2'b10);
        end
        check("R7", "never expired", int'(ctr_ready), 0);
        ticks(5);
        check("R7", "expired when both idle", int'(ctr_ready), 1);

        // R2: disable ch0 only, mode stays on; then ch1, normal start works
        cur_req = "R2";
        cmd(0, 4'hC);
        xfer(2'b01); ticks(1);
        check("R2", "ch0 off ignored", int'(ctr_ready), 1);
        xfer(2'b10);
        check("R2", "ch1 still on", int'(count), 4);
        cmd(1, 4'hC);
        preload_hi = 8'h01; preload_lo = 8'h02;
        cmd(0, 4'h8);
        check("R2", "normal mode back", int'(count), 16'h0102);
        cur_req = "R4";
        ticks(20);
        check("R4", "wide count", int'(count), 16'h0102 - 20);

        // R5: zero preload expires on first tick
        cur_req = "R5";
        preload_hi = 8'h00; preload_lo = 8'h00;
        cmd(0, 4'h8); ticks(1);
        check("R5", "zero preload", int'(ctr_ready), 1);
        cyc();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule